// File: doc/BRIEF.md
# I2C Line Glitch Filter with Stop Detector

This block sits between the SCL and SDA pins and the rest of an I2C controller. Each raw line passes through a two-flop synchroniser and then through its own glitch filter. The filter length is a 5-bit factor counted in bus clock cycles and can be changed at run time. A factor of zero turns the filter off, so the synchronised line goes straight to the output.

A detector watches the two filtered lines for a STOP condition. A STOP is a rising edge on filtered SDA while filtered SCL is high. When it sees one, it sets a sticky stop flag. If the stop interrupt is enabled, it also sets a general interrupt flag, and that flag drives the interrupt request. Software clears both flags by writing 1 to them. The stop flag must be cleared before the general flag, or the general flag comes straight back.

Software reaches the block through one write strobe. The strobe loads the factor and the enable, and it carries one clear bit for each flag.

Top module: `i2c_glitch_stop`

## Requirements
- R1: After reset, `scl_filt` and `sda_filt` are 1, and `stop_flag` and `irq` are 0.
- R2: With factor 0 the filter is bypassed. A raw level driven just after clock edge E0 appears on the filtered output after edge E0+2, which is the synchroniser delay only.
- R3: With factor n from 1 to 31, a raw pulse that lasts n cycles or fewer never changes the filtered output.
- R4: With factor n from 1 to 31, a raw level that is held shows on the filtered output after edge E0+n+3. That is two synchroniser cycles plus n+1 cycles of the level held steady.
- R5: SCL and SDA are filtered independently. Activity on one line does not change when the other line's output changes.
- R6: A rising edge of `sda_filt` while `scl_filt` is high sets `stop_flag` at the next clock edge.
- R7: `stop_flag` stays at 1 until a write with `wr_stop_clr`=1. A write with `wr_stop_clr`=0 leaves it unchanged.
- R8: When a stop-clear write lands in the same cycle as a new STOP event, `stop_flag` stays 1.
- R9: `irq` follows the general flag. A STOP sets that flag only while the stop enable is 1. With the enable at 0, `stop_flag` is still set but `irq` stays 0.
- R10: When the enable is 1, `stop_flag` is 1 and an irq-clear write arrives, `irq` stays 1. After `stop_flag` has been cleared, an irq-clear write drops `irq` to 0.
- R11: `irq` is cleared only by a write with `wr_irq_clr`=1. A write with that bit at 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_raw | input | 1 | Raw clock line from the pin |
| sda_raw | input | 1 | Raw data line from the pin |
| wr_en | input | 1 | Write strobe for the fields below |
| wr_factor | input | 5 | Filter factor, 0 = bypass, n = absorb pulses of n cycles or fewer |
| wr_stop_ie | input | 1 | Stop interrupt enable |
| wr_stop_clr | input | 1 | Write 1 to clear the stop flag |
| wr_irq_clr | input | 1 | Write 1 to clear the general interrupt flag |
| scl_filt | output | 1 | Filtered clock line |
| sda_filt | output | 1 | Filtered data line |
| stop_flag | output | 1 | Sticky STOP detected flag |
| irq | output | 1 | Interrupt request, equal to the general flag |

## Verification
The assertions assume that the raw lines and the write fields change only between clock edges and stay steady across each rising edge. They also assume that reset is held for at least one edge before checking begins. The bench drives every input on the falling edge and holds reset for several cycles. It changes the factor only while both lines are idle and equal to their filtered levels. This means no count is in progress when the length changes, so the reference timing stays exact.

// File: rtl/i2cflt_pkg.sv
// Package: shared widths and line indices for the I2C glitch filter block.
// Assumes two bus lines, with SCL at index 0 and SDA at index 1.
package i2cflt_pkg;
    localparam int FACTOR_W = 5;
    localparam int NUM_LINES = 2;
    localparam int LINE_SCL = 0;
    localparam int LINE_SDA = 1;
    typedef logic [FACTOR_W-1:0] factor_t;
endpackage

// File: rtl/i2cflt_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous pin inputs.
// Assumes the pins idle high, so both stages reset to 1.
module i2cflt_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);
    logic [WIDTH-1:0] stage1;

    // Purpose: move the pins into the clock domain through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '1;
            pin_sync <= '1;
        end else begin
            stage1   <= pin_in;
            pin_sync <= stage1;
        end
    end
endmodule

// File: rtl/i2cflt_glitch.sv
// Module: glitch filter for one line, with a programmable length.
// With factor 0 the synchronised input passes straight through.
// With factor n the output takes a new level only after the input has held it
// for n+1 cycles in a row. The count restarts whenever the input returns to
// the output level. Assumes line_in is already synchronised.
module i2cflt_glitch #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] factor,
    input  logic             line_in,
    output logic             line_out
);
    logic             held;
    logic [CNT_W-1:0] run;
    logic             bypass;

    assign bypass = (factor == '0);

    // Purpose: count how long the input has differed and commit it at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b1;
            run  <= '0;
        end else if (bypass) begin
            held <= line_in;
            run  <= '0;
        end else if (line_in == held) begin
            run  <= '0;
        end else if (run >= factor) begin
            held <= line_in;
            run  <= '0;
        end else begin
            run  <= run + 1'b1;
        end
    end

    // Purpose: choose between the bypass path and the filtered level.
    assign line_out = bypass ? line_in : held;

    AST_SETTLED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && line_in == held) |=> (held == $past(held))); // R3

    AST_COMMIT_MATCHES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (held != $past(held)) |-> (held == $past(line_in))); // R4
endmodule

// File: rtl/i2cflt_stopflags.sv
// Module: STOP detector plus the sticky stop flag and the general interrupt flag.
// A STOP is a rising edge of filtered SDA while filtered SCL is high. Each flag
// is cleared by writing 1 to it. The general flag is set again while the stop
// flag is set and the enable is on. Assumes both filtered lines idle high.
module i2cflt_stopflags (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    input  logic stop_ie,
    input  logic stop_clr,
    input  logic gen_clr,
    output logic stop_flag,
    output logic gen_flag
);
    logic sda_prev;
    logic stop_ev;

    // Purpose: remember the previous filtered SDA level so edges can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_f;
    end

    assign stop_ev = sda_f && !sda_prev && scl_f;

    // Purpose: keep the stop flag set until it is cleared; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stop_flag <= 1'b0;
        else        stop_flag <= stop_ev || (stop_flag && !stop_clr);
    end

    // Purpose: keep the general flag set; the enabled stop flag sets it again after a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) gen_flag <= 1'b0;
        else        gen_flag <= (stop_ie && (stop_ev || stop_flag)) || (gen_flag && !gen_clr);
    end

    AST_STOP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> stop_flag); // R6

    AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_flag && !stop_clr) |=> stop_flag); // R7

    AST_GEN_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ie && stop_flag) |=> gen_flag); // R10

    AST_GEN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_flag) |-> $past(stop_ie)); // R9
endmodule

// File: rtl/i2c_glitch_stop.sv
// Module: top level. It synchronises SCL and SDA, filters each line, and detects STOP.
// It holds the filter factor and the stop enable, which the write strobe loads.
// Assumes write fields are valid only while wr_en is high.
module i2c_glitch_stop #(
    parameter int FACTOR_W = i2cflt_pkg::FACTOR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_raw,
    input  logic                sda_raw,
    input  logic                wr_en,
    input  logic [FACTOR_W-1:0] wr_factor,
    input  logic                wr_stop_ie,
    input  logic                wr_stop_clr,
    input  logic                wr_irq_clr,
    output logic                scl_filt,
    output logic                sda_filt,
    output logic                stop_flag,
    output logic                irq
);
    localparam int LINES = i2cflt_pkg::NUM_LINES;

    logic [FACTOR_W-1:0] factor_q;
    logic                stop_ie_q;
    logic [LINES-1:0]    pins;
    logic [LINES-1:0]    pins_sync;
    logic [LINES-1:0]    pins_filt;

    // Purpose: load the filter factor and the stop enable on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            factor_q  <= '0;
            stop_ie_q <= 1'b0;
        end else if (wr_en) begin
            factor_q  <= wr_factor;
            stop_ie_q <= wr_stop_ie;
        end
    end

    assign pins[i2cflt_pkg::LINE_SCL] = scl_raw;
    assign pins[i2cflt_pkg::LINE_SDA] = sda_raw;

    i2cflt_sync #(.WIDTH(LINES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pins),
        .pin_sync (pins_sync)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_line
        i2cflt_glitch #(.CNT_W(FACTOR_W)) filt_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .factor   (factor_q),
            .line_in  (pins_sync[g]),
            .line_out (pins_filt[g])
        );
    end

    assign scl_filt = pins_filt[i2cflt_pkg::LINE_SCL];
    assign sda_filt = pins_filt[i2cflt_pkg::LINE_SDA];

    i2cflt_stopflags flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_filt),
        .sda_f     (sda_filt),
        .stop_ie   (stop_ie_q),
        .stop_clr  (wr_en && wr_stop_clr),
        .gen_clr   (wr_en && wr_irq_clr),
        .stop_flag (stop_flag),
        .gen_flag  (irq)
    );

    AST_RESET_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!stop_flag && !irq)); // R1
endmodule

// File: tb/i2c_glitch_stop_tb_top.sv
module i2c_glitch_stop_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_raw = 1'b1, sda_raw = 1'b1;
    logic       wr_en = 1'b0;
    logic [4:0] wr_factor = '0;
    logic       wr_stop_ie = 1'b0, wr_stop_clr = 1'b0, wr_irq_clr = 1'b0;
    logic       scl_filt, sda_filt, stop_flag, irq;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_glitch_stop dut_i (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .wr_en(wr_en), .wr_factor(wr_factor), .wr_stop_ie(wr_stop_ie),
        .wr_stop_clr(wr_stop_clr), .wr_irq_clr(wr_irq_clr),
        .scl_filt(scl_filt), .sda_filt(sda_filt), .stop_flag(stop_flag), .irq(irq)
    );

    // Reference model built from the requirements (R2, R3, R4, R6..R11)
    logic [1:0] m_s1, m_s2, m_held;
    int         m_run [2];
    int         m_n;
    logic       m_ie, m_stop, m_irq, m_sda_prev;

    function automatic logic m_out(int idx);
        return (m_n == 0) ? m_s2[idx] : m_held[idx];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 2'b11; m_s2 = 2'b11; m_held = 2'b11;
            m_run[0] = 0; m_run[1] = 0; m_n = 0;
            m_ie = 0; m_stop = 0; m_irq = 0; m_sda_prev = 1;
        end else begin
            logic ev, old_stop;
            ev = m_out(1) && !m_sda_prev && m_out(0);
            old_stop = m_stop;
            m_stop = ev || (m_stop && !(wr_en && wr_stop_clr));
            m_irq = (m_ie && (ev || old_stop)) || (m_irq && !(wr_en && wr_irq_clr));
            m_sda_prev = m_out(1);
            for (int i = 0; i < 2; i++) begin
                if (m_n == 0) begin m_held[i] = m_s2[i]; m_run[i] = 0; end
                else if (m_s2[i] == m_held[i]) m_run[i] = 0;
                else if (m_run[i] >= m_n) begin m_held[i] = m_s2[i]; m_run[i] = 0; end
                else m_run[i]++;
            end
            m_s2 = m_s1;
            m_s1 = {sda_raw, scl_raw};
            if (wr_en) begin m_n = int'(wr_factor); m_ie = wr_stop_ie; end
        end
    end

    task automatic chk(string req, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick(int k = 1);
        repeat (k) @(negedge clk);
    endtask

    task automatic write(int f, logic ie, logic sc, logic ic);
        wr_en = 1; wr_factor = 5'(f); wr_stop_ie = ie; wr_stop_clr = sc; wr_irq_clr = ic;
        tick();
        wr_en = 0; wr_stop_clr = 0; wr_irq_clr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; scl_raw = 1; sda_raw = 1; wr_en = 0;
        tick(4);
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int n, cnt;
        bit bad;
        void'($urandom(32'd1234));
        do_reset();
        tick();
        chk("R1 scl_filt reset", scl_filt, 1'b1);
        chk("R1 sda_filt reset", sda_filt, 1'b1);
        chk("R1 stop_flag reset", stop_flag, 1'b0);
        chk("R1 irq reset", irq, 1'b0);

        // Random phase against the reference model (R2 R3 R4 R5 R6 R9 R10 R11)
        for (int seg = 0; seg < 12; seg++) begin
            scl_raw = 1; sda_raw = 1;
            tick(40);
            write($urandom_range(0, 7), 1'b1, 1'b0, 1'b0);
            for (int c = 0; c < 300; c++) begin
                int len;
                len = $urandom_range(1, 10);
                if ($urandom_range(0, 1)) scl_raw = ~scl_raw;
                else sda_raw = ~sda_raw;
                for (int j = 0; j < len; j++) begin
                    if ($urandom_range(0, 15) == 0) begin
                        wr_en = 1; wr_factor = 5'(m_n); wr_stop_ie = 1;
                        wr_stop_clr = 1'($urandom_range(0, 1)); wr_irq_clr = 1'($urandom_range(0, 1));
                    end else begin
                        wr_en = 0; wr_stop_clr = 0; wr_irq_clr = 0;
                    end
                    tick();
                    chk("R4 random scl_filt", scl_filt, m_out(0));
                    chk("R4 random sda_filt", sda_filt, m_out(1));
                    chk("R6 random stop_flag", stop_flag, m_stop);
                    chk("R10 random irq", irq, m_irq);
                end
            end
            wr_en = 0; wr_stop_clr = 0; wr_irq_clr = 0;
        end

        // Directed corner cases
        do_reset();
        scl_raw = 0;
        tick(5);
        sda_raw = 0;
        tick();
        chk("R2 bypass before second edge", sda_filt, 1'b1);
        tick();
        chk("R2 bypass after second edge", sda_filt, 1'b0);
        tick(3);

        n = 4;
        write(n, 1'b1, 1'b0, 1'b0);
        tick(3);
        sda_raw = 1; tick(n); sda_raw = 0;
        bad = 0;
        for (int k = 0; k < 12; k++) begin tick(); if (sda_filt !== 1'b0) bad = 1; end
        chk("R3 pulse of n cycles suppressed", bad, 1'b0);

        sda_raw = 1; cnt = 0;
        for (int k = 1; k <= 20; k++) begin tick(); if (sda_filt === 1'b1) begin cnt = k; break; end end
        chk("R4 latency is n+3 edges", cnt == n + 3, 1'b1);

        scl_raw = 1; cnt = 0; bad = 0;
        for (int k = 1; k <= 20; k++) begin
            sda_raw = 1'(k % 2 == 1 ? 0 : 1);
            tick();
            if (sda_filt !== 1'b1) bad = 1;
            if (scl_filt === 1'b1 && cnt == 0) cnt = k;
        end
        sda_raw = 1; tick(8);
        chk("R5 scl latency unaffected by sda toggling", cnt == n + 3, 1'b1);
        chk("R5 sda_filt held during toggling", bad, 1'b0);
        chk("R5 no stop without filtered edge", stop_flag, 1'b0);

        sda_raw = 0; tick(10);
        sda_raw = 1; tick(n + 2);
        chk("R6 stop flag not before edge", stop_flag, 1'b0);
        tick();
        chk("R6 sda_filt rose", sda_filt, 1'b1);
        chk("R6 stop flag one edge after rise", stop_flag, 1'b0);
        tick();
        chk("R6 stop flag set", stop_flag, 1'b1);
        chk("R9 irq with enable", irq, 1'b1);

        write(n, 1'b1, 1'b0, 1'b0); tick();
        chk("R7 write of 0 keeps stop_flag", stop_flag, 1'b1);
        chk("R11 write of 0 keeps irq", irq, 1'b1);
        write(n, 1'b1, 1'b0, 1'b1); tick();
        chk("R10 irq re-raised while stop set", irq, 1'b1);
        write(n, 1'b1, 1'b1, 1'b0); tick();
        chk("R7 stop cleared by write 1", stop_flag, 1'b0);
        chk("R10 irq still set after stop clear", irq, 1'b1);
        write(n, 1'b1, 1'b0, 1'b1); tick();
        chk("R10 irq cleared in correct order", irq, 1'b0);

        write(0, 1'b0, 1'b0, 1'b0);
        sda_raw = 0; tick(4);
        sda_raw = 1; tick(4);
        chk("R9 stop flag set with enable off", stop_flag, 1'b1);
        chk("R9 irq stays low with enable off", irq, 1'b0);
        write(0, 1'b0, 1'b1, 1'b0); tick();
        chk("R7 stop cleared", stop_flag, 1'b0);

        sda_raw = 0; tick(4);
        sda_raw = 1; tick(2);
        write(0, 1'b0, 1'b1, 1'b0);
        chk("R8 clear colliding with new stop", stop_flag, 1'b1);
        write(0, 1'b0, 1'b1, 1'b0);
        chk("R8 later clear takes effect", stop_flag, 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule